// File: doc/BRIEF.md
# Software-Triggered Interrupt Register Block

This block is a small memory-mapped register file that drives one level-sensitive interrupt line. It keeps two general output data words, a control word, an interrupt status word and a software interrupt word. All of them are 32 bits wide and can be read back over a simple register bus. The bus has a byte address, a write enable with write data, and a read enable with read data.

The interrupt line is not computed from register contents. It is a held level. Particular bits in writes to the second data word, the control word and the status word raise or drop it. A write to the software set offset always raises it, and a write to the software clear offset always drops it. The line keeps its level until a later write changes it.

Firmware typically uses the block as a doorbell. It raises the line through the set offset, or through bit 29 of a data-word-B write. It acknowledges through the clear offset, or by writing bit 16 to the control word or bit 16 or 29 to the status word.

Top module: `sw_int_regs`

## Requirements
- R1: After reset every stored word reads as zero (control reads as 0x0002_0000), and `intLine` is low.
- R2: A write to byte offset 0x28 stores data word A in full, and a read of 0x28 returns it. Such a write never changes `intLine`.
- R3: A write to offset 0x2C stores data word B in full. If bit 29 of the written value is 1, `intLine` is high from the next clock edge.
- R4: A write to offset 0x4C stores the control word. If bit 16 of the written value is 1, `intLine` is low from the next clock edge. A read of 0x4C returns the stored word with bit 17 forced to 1.
- R5: A write to offset 0x50 stores the status word exactly as written, with no bit clearing. If bit 16 or bit 29 of the written value is 1, `intLine` is low from the next edge.
- R6: A write to offset 0x1F0 ORs the value into the software interrupt word and sets `intLine` high from the next edge, even when the value is zero.
- R7: A write to offset 0x1F4 clears the set bits of the value in the software interrupt word and sets `intLine` low from the next edge, even when the value is zero. Reads of 0x1F0 and of 0x1F4 both return the software interrupt word.
- R8: Only the six exact offsets above are mapped; a misaligned address such as 0x29 is unmapped. A read of an unmapped address returns zero. A write to an unmapped address changes neither any register nor `intLine`.
- R9: A write that asks neither to raise nor to drop the line, or a cycle with no write, leaves `intLine` at its previous level.
- R10: Read data is valid in the same cycle as `busRdEn`, with no clock edge in between. When `busRdEn` is low, `busRdData` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (12) | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W (32) | Write data |
| busRdEn | input | 1 | Read request |
| busRdData | output | DATA_W (32) | Read data, combinational |
| intLine | output | 1 | Held interrupt level |

## Verification
The hardest case to reach is a write that carries one of the trigger bit positions but goes to a register that must not act on it. Examples are bit 29 written to data word A, bit 16 written to data word B, and either bit written to an unmapped or misaligned address while the line is already high. The stimulus first raises the line, then sends these decoy writes, and only afterwards drops the line through each of the three drop paths. Any wrong decode therefore shows up as a level change at the port. A reset applied while the line is high and all words are non-zero checks that every register clears.

// File: rtl/sw_int_pkg.sv
package sw_int_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned OFS_W = 12;

  // Byte offsets; firmware depends on these exact values.
  localparam logic [OFS_W-1:0] OFS_DATA_A = 12'h028;
  localparam logic [OFS_W-1:0] OFS_DATA_B = 12'h02C;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h04C;
  localparam logic [OFS_W-1:0] OFS_STAT   = 12'h050;
  localparam logic [OFS_W-1:0] OFS_SW_SET = 12'h1F0;
  localparam logic [OFS_W-1:0] OFS_SW_CLR = 12'h1F4;

  // Trigger and forced bit positions.
  localparam int unsigned BIT_RAISE     = 29;
  localparam int unsigned BIT_CTRL_DROP = 16;
  localparam int unsigned BIT_STAT_LO   = 16;
  localparam int unsigned BIT_STAT_HI   = 29;
  localparam int unsigned BIT_FORCE_ONE = 17;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA_A,
    SEL_DATA_B,
    SEL_CTRL,
    SEL_STAT,
    SEL_SWORD
  } regSel_e;

  typedef struct packed {
    logic    wrDataA;
    logic    wrDataB;
    logic    wrCtrl;
    logic    wrStat;
    logic    wrSwSet;
    logic    wrSwClr;
    regSel_e rdSel;
  } regStb_t;

endpackage

// File: rtl/sw_int_ctrl.sv
module sw_int_ctrl
  import sw_int_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned ADDR_W = OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output regStb_t           stb,
  output logic              intLine
);

  regSel_e addrHit;
  logic    hitSet;
  logic    hitClr;
  logic    raiseReq;
  logic    dropReq;

  // Exact-match decode: misaligned or unlisted addresses fall to SEL_NONE.
  always_comb begin
    addrHit = SEL_NONE;
    hitSet  = 1'b0;
    hitClr  = 1'b0;
    case (busAddr)
      ADDR_W'(OFS_DATA_A): addrHit = SEL_DATA_A;
      ADDR_W'(OFS_DATA_B): addrHit = SEL_DATA_B;
      ADDR_W'(OFS_CTRL):   addrHit = SEL_CTRL;
      ADDR_W'(OFS_STAT):   addrHit = SEL_STAT;
      ADDR_W'(OFS_SW_SET): begin addrHit = SEL_SWORD; hitSet = 1'b1; end
      ADDR_W'(OFS_SW_CLR): begin addrHit = SEL_SWORD; hitClr = 1'b1; end
      default:             addrHit = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.wrDataA = busWrEn && (addrHit == SEL_DATA_A);
    stb.wrDataB = busWrEn && (addrHit == SEL_DATA_B);
    stb.wrCtrl  = busWrEn && (addrHit == SEL_CTRL);
    stb.wrStat  = busWrEn && (addrHit == SEL_STAT);
    stb.wrSwSet = busWrEn && hitSet;
    stb.wrSwClr = busWrEn && hitClr;
    stb.rdSel   = busRdEn ? addrHit : SEL_NONE;
  end

  always_comb begin
    raiseReq = (stb.wrDataB && busWrData[BIT_RAISE]) || stb.wrSwSet;
    dropReq  = (stb.wrCtrl && busWrData[BIT_CTRL_DROP])
            || (stb.wrStat && (busWrData[BIT_STAT_LO] || busWrData[BIT_STAT_HI]))
            || stb.wrSwClr;
  end

  // Held interrupt level; only one write per cycle, so raise and drop never coincide.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intLine <= 1'b0;
    else if (raiseReq) intLine <= 1'b1;
    else if (dropReq)  intLine <= 1'b0;
  end

  assert_b_raise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_DATA_B) && busWrData[BIT_RAISE]) |=> intLine);

  assert_ctrl_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_CTRL) && busWrData[BIT_CTRL_DROP]) |=> !intLine);

  assert_stat_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_STAT)
     && (busWrData[BIT_STAT_LO] || busWrData[BIT_STAT_HI])) |=> !intLine);

  assert_set_raise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_SW_SET)) |=> intLine);

  assert_clr_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_SW_CLR)) |=> !intLine);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(intLine));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrDataA, stb.wrDataB, stb.wrCtrl, stb.wrStat, stb.wrSwSet, stb.wrSwClr}));

endmodule

// File: rtl/sw_int_dpath.sv
module sw_int_dpath
  import sw_int_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] dataAReg;
  logic [DATA_W-1:0] dataBReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] swWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataAReg <= '0;
      dataBReg <= '0;
      ctrlReg  <= '0;
      statReg  <= '0;
    end else begin
      if (stb.wrDataA) dataAReg <= wrData;
      if (stb.wrDataB) dataBReg <= wrData;
      if (stb.wrCtrl)  ctrlReg  <= wrData;
      if (stb.wrStat)  statReg  <= wrData;
    end
  end

  // Software interrupt word: per-bit set/clear cells.
  for (genvar b = 0; b < DATA_W; b++) begin : g_swBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           swWord[b] <= 1'b0;
      else if (stb.wrSwSet && wrData[b])   swWord[b] <= 1'b1;
      else if (stb.wrSwClr && wrData[b])   swWord[b] <= 1'b0;
    end
  end

  logic [DATA_W-1:0] forceMask;
  assign forceMask = DATA_W'(1) << BIT_FORCE_ONE;

  always_comb begin
    case (stb.rdSel)
      SEL_DATA_A: rdData = dataAReg;
      SEL_DATA_B: rdData = dataBReg;
      SEL_CTRL:   rdData = ctrlReg | forceMask;
      SEL_STAT:   rdData = statReg;
      SEL_SWORD:  rdData = swWord;
      default:    rdData = '0;
    endcase
  end

  assert_ctrl_force_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == SEL_CTRL) |-> rdData[BIT_FORCE_ONE]);

  assert_stat_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStat |=> (statReg == $past(wrData)));

  assert_sw_or_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSwSet |=> ((swWord & $past(wrData)) == $past(wrData)));

  assert_sw_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSwClr |=> ((swWord & $past(wrData)) == '0));

  assert_a_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDataA |=> (dataAReg == $past(wrData)));

endmodule

// File: rtl/sw_int_regs.sv
module sw_int_regs
  import sw_int_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned ADDR_W = OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              intLine
);

  regStb_t stb;

  sw_int_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .stb       (stb),
    .intLine   (intLine)
  );

  sw_int_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .rdData (busRdData)
  );

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0));

endmodule

// File: tb/test_sw_int_regs.sv
module test_sw_int_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        intLine;

  int    checkCnt = 0;
  int    failCnt  = 0;
  string curTag   = "R1";

  // Behavioural reference state
  logic [31:0] mA, mB, mCtrl, mStat, mSw;
  logic        mInt;

  sw_int_regs i_sw_int_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .intLine   (intLine)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h028: return mA;
      12'h02C: return mB;
      12'h04C: return mCtrl | 32'h0002_0000;
      12'h050: return mStat;
      12'h1F0, 12'h1F4: return mSw;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mA = '0; mB = '0; mCtrl = '0; mStat = '0; mSw = '0; mInt = 1'b0;
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h028: mA = d;
      12'h02C: begin mB = d; if (d[29]) mInt = 1'b1; end
      12'h04C: begin mCtrl = d; if (d[16]) mInt = 1'b0; end
      12'h050: begin mStat = d; if (d[16] || d[29]) mInt = 1'b0; end
      12'h1F0: begin mSw = mSw | d; mInt = 1'b1; end
      12'h1F4: begin mSw = mSw & ~d; mInt = 1'b0; end
      default: ;
    endcase
  endtask

  // Per-clock comparison of the interrupt level and idle read data.
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      check({curTag, " intLine"}, {31'b0, intLine}, {31'b0, mInt});
      if (!busRdEn) check("R10 idle read", busRdData, 32'h0);
    end
  end

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    curTag = tag;
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    modelWrite(a, d);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2;
    check({tag, " read"}, busRdData, modelRead(a));
    #1;
    busRdEn = 1'b0;
  endtask

  task automatic rdAll(input string tag);
    rd(tag, 12'h028); rd(tag, 12'h02C); rd(tag, 12'h04C);
    rd(tag, 12'h050); rd(tag, 12'h1F0); rd(tag, 12'h1F4);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdAll("R1");

    // R2: data word A, no interrupt effect even with bit 29
    wr("R2", 12'h028, 32'hDEAD_BEEF); rd("R2", 12'h028);
    wr("R2", 12'h028, 32'h2001_0000); rd("R2", 12'h028);

    // R3: data word B without and with bit 29
    wr("R3", 12'h02C, 32'h0001_1234); rd("R3", 12'h02C);
    wr("R3", 12'h02C, 32'h2000_0001); rd("R3", 12'h02C);

    // R9: non-acting writes keep the line high
    wr("R9", 12'h028, 32'h2001_0000);
    wr("R9", 12'h04C, 32'h0000_00FF);
    wr("R9", 12'h050, 32'hDFFE_FFFF);
    wr("R9", 12'h02C, 32'h0001_0000);
    repeat (4) @(negedge clk);

    // R4: control drop and forced bit on readback
    wr("R4", 12'h04C, 32'h0001_0000); rd("R4", 12'h04C);
    wr("R4", 12'h04C, 32'h0000_0000); rd("R4", 12'h04C);
    wr("R4", 12'h04C, 32'hFFFD_FFFF); rd("R4", 12'h04C);

    // R5: status stored as written, drop on bit 29 and on bit 16
    wr("R5", 12'h02C, 32'h2000_0000);
    wr("R5", 12'h050, 32'h2000_0000); rd("R5", 12'h050);
    wr("R5", 12'h050, 32'h2000_0000); rd("R5", 12'h050);
    wr("R5", 12'h02C, 32'h2000_0000);
    wr("R5", 12'h050, 32'h0001_0005); rd("R5", 12'h050);

    // R6: set offset ORs and always raises, even with zero
    wr("R6", 12'h1F0, 32'h0000_0000); rd("R6", 12'h1F0);
    wr("R6", 12'h1F4, 32'hFFFF_FFFF);
    wr("R6", 12'h1F0, 32'h0000_0005);
    wr("R6", 12'h1F0, 32'h0000_00A0);
    rd("R6", 12'h1F0); rd("R6", 12'h1F4);

    // R7: clear offset clears and always drops, even with zero
    wr("R7", 12'h1F4, 32'h0000_0000); rd("R7", 12'h1F4);
    wr("R7", 12'h1F0, 32'h0000_0000);
    wr("R7", 12'h1F4, 32'h0000_0005);
    rd("R7", 12'h1F4); rd("R7", 12'h1F0);

    // R8: unmapped and misaligned accesses while the line is high
    wr("R8", 12'h1F0, 32'h8000_0000);
    wr("R8", 12'h100, 32'hFFFF_FFFF);
    wr("R8", 12'h029, 32'hFFFF_FFFF);
    wr("R8", 12'h1F5, 32'hFFFF_FFFF);
    wr("R8", 12'h051, 32'hFFFF_FFFF);
    wr("R8", 12'h04D, 32'hFFFF_FFFF);
    rdAll("R8");
    rd("R8", 12'h100); rd("R8", 12'h02A); rd("R8", 12'h1F8); rd("R8", 12'h000);
    wr("R8", 12'h1F4, 32'h0000_0000);
    wr("R8", 12'h02D, 32'h2000_0000);
    wr("R8", 12'h1F2, 32'h0000_0000);
    rdAll("R8");

    // R1: reset while the line is high and words are non-zero
    wr("R1", 12'h028, 32'h1111_1111);
    wr("R1", 12'h050, 32'h0000_3333);
    wr("R1", 12'h02C, 32'h2222_2222);
    doReset();
    curTag = "R1";
    rdAll("R1");

    repeat (2) @(negedge clk);
    summary();
  end

endmodule